// File: doc/BRIEF.md
# Input Edge Counting Timer

This block is a 16-bit down-counter that advances on edges of an external capture input, not on clock ticks. Software programs a start value and a stop value, chooses which edge polarity qualifies, and sets an enable bit. Each qualifying edge lowers the counter by one. When the counter reaches the stop value, the block does four things in the same cycle: it sets a sticky status flag, reloads the start value into the counter, clears its own enable bit, and raises an interrupt if the mask allows it. Edges that arrive after that point are ignored until software sets the enable bit again.

The capture input is asynchronous. It passes through a two-flop synchronizer, and edges are found by comparing the synchronized sample with the sample before it. Software reaches all state through a small word-addressed register port, with combinational read data and single-cycle writes.

Register map (word addresses):
- 0, control: bit0 enable, bits[2:1] edge select, bit3 capture mode.
- 1, start value.
- 2, stop value.
- 3, interrupt mask: bit0.
- 4, raw status: bit0. Read it, or write 1 to clear it.
- 5, masked status: bit0. Read-only.
- 6, live counter value. Read-only.

Top module: `edge_count_timer`

## Requirements
- R1: After reset, the counter, control, start, stop, mask and status registers all read 0, and `irq_o` is low.
- R2: Each qualifying edge lowers the counter by exactly one. Without edges the counter holds its value through any number of clocks.
- R3: Edge select in control bits[2:1] works as follows: 00 counts rising edges only, 01 counts falling edges only, and 10 or 11 count both edges.
- R4: The number of edges counted equals the start value minus the stop value. With start 0x000A and stop 0x0006, the fourth edge sets raw status bit0.
- R5: The masked status (address 5, bit0) and `irq_o` are high only while raw status is 1 and mask bit0 is 1.
- R6: On reaching the stop value, the counter is reloaded from the start register and control bit0 (enable) is cleared by hardware.
- R7: While enable is 0, edges on `cap_i` leave the counter unchanged. This includes edges in both-edge mode that follow a match.
- R8: While capture mode (control bit3) is 1, edges do not count, even if enable is 1.
- R9: Writing 1 to raw status bit0 clears it. If a match happens in the same cycle as that write, the status ends up set.
- R10: A write to the start register while enable is 0 also loads the counter. A write while enable is 1 leaves the counter unchanged.
- R11: If the stop value is not below the start value, the counter wraps from 0x0000 to 0xFFFF and stops only when it equals the stop value.
- R12: An edge on `cap_i` changes the counter on the third rising clock edge after the input changes, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data (combinational) |
| cap_i | input | 1 | Asynchronous capture input |
| irq_o | output | 1 | Masked match interrupt |

## Verification
Two events can land in the same clock: a hardware match that sets raw status, and a software write-one-to-clear of that status. The bench first leaves the status set from an earlier match. It then re-arms the counter one edge away from the stop value and toggles `cap_i`. It issues the clear write so that the write lands on the third clock after the toggle, which is the same clock in which the counter reaches the stop value. The bench passes the case only if the status still reads 1 and the counter reads the reloaded start value.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_START  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STOP   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RAW    = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASKED = 3'd5;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd6;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_ANY0 = 2'b10,
    EDGE_ANY1 = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic      mode;
    edge_sel_e sel;
    logic      en;
  } ctrl_t;
endpackage

// File: rtl/ect_sync_edge.sv
module ect_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= cap_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic [CNT_W-1:0] stop_i,
  input  logic             preload_i,
  input  logic [CNT_W-1:0] preload_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_dec;
  logic             step;

  assign step    = active_i & hit_i;
  assign cnt_dec = cnt_q - CNT_W'(1);  // wraps 0 -> all ones
  assign match_o = step && (cnt_dec == stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (match_o)   cnt_q <= start_i;
    else if (step)      cnt_q <= cnt_dec;
    else if (preload_i) cnt_q <= preload_val_i;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ect_regs.sv
module ect_regs
  import ect_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              hw_match_i,
  input  logic [DATA_W-1:0] cnt_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] start_o,
  output logic [DATA_W-1:0] stop_o,
  output logic              mask_o,
  output logic              raw_o,
  output logic              preload_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] start_q, stop_q;
  logic              mask_q, raw_q;
  logic              wr_ctrl, wr_start, wr_stop, wr_mask, wr_raw;

  assign wr_ctrl  = we_i && (addr_i == A_CTRL);
  assign wr_start = we_i && (addr_i == A_START);
  assign wr_stop  = we_i && (addr_i == A_STOP);
  assign wr_mask  = we_i && (addr_i == A_MASK);
  assign wr_raw   = we_i && (addr_i == A_RAW);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= '0;
      stop_q  <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.mode <= wdata_i[3];
        ctrl_q.sel  <= edge_sel_e'(wdata_i[2:1]);
      end
      // hardware stop wins over a software enable write
      if (hw_match_i)   ctrl_q.en <= 1'b0;
      else if (wr_ctrl) ctrl_q.en <= wdata_i[0];
      if (wr_start) start_q <= wdata_i;
      if (wr_stop)  stop_q  <= wdata_i;
      if (wr_mask)  mask_q  <= wdata_i[0];
      // set wins over write-one-to-clear
      if (hw_match_i)                raw_q <= 1'b1;
      else if (wr_raw && wdata_i[0]) raw_q <= 1'b0;
    end
  end

  assign preload_o = wr_start && !ctrl_q.en;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:   rdata_o[3:0] = ctrl_q;
      A_START:  rdata_o      = start_q;
      A_STOP:   rdata_o      = stop_q;
      A_MASK:   rdata_o[0]   = mask_q;
      A_RAW:    rdata_o[0]   = raw_q;
      A_MASKED: rdata_o[0]   = raw_q & mask_q;
      A_COUNT:  rdata_o      = cnt_i;
      default:  rdata_o      = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;
  assign mask_o  = mask_q;
  assign raw_o   = raw_q;
endmodule

// File: rtl/edge_count_timer.sv
module edge_count_timer
  import ect_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              cap_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] start_val, stop_val, cnt;
  logic              mask, raw, preload, match;
  logic              rise, fall, hit, active;

  ect_sync_edge #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    unique case (ctrl.sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
  end

  assign active = ctrl.en & ~ctrl.mode;

  ect_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .active_i      (active),
    .hit_i         (hit),
    .start_i       (start_val),
    .stop_i        (stop_val),
    .preload_i     (preload),
    .preload_val_i (wdata_i),
    .cnt_o         (cnt),
    .match_o       (match)
  );

  ect_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .hw_match_i (match),
    .cnt_i      (cnt),
    .ctrl_o     (ctrl),
    .start_o    (start_val),
    .stop_o     (stop_val),
    .mask_o     (mask),
    .raw_o      (raw),
    .preload_o  (preload)
  );

  assign irq_o = raw & mask;
endmodule

// File: rtl/ect_checker.sv
module ect_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en,
  input logic              mode,
  input logic              hit,
  input logic              match,
  input logic              preload,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] start_val,
  input logic              raw,
  input logic              mask,
  input logic              irq_o
);
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !mode && hit && !match) |=> cnt == $past(cnt) - DATA_W'(1));

  assert_irq_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (raw && mask));

  assert_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> (!en && cnt == $past(start_val)));

  assert_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !preload) |=> $stable(cnt));

  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode && !preload) |=> $stable(cnt));

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> raw);
endmodule

bind edge_count_timer ect_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en        (ctrl.en),
  .mode      (ctrl.mode),
  .hit       (hit),
  .match     (match),
  .preload   (preload),
  .cnt       (cnt),
  .start_val (start_val),
  .raw       (raw),
  .mask      (mask),
  .irq_o     (irq_o)
);

// File: tb/edge_count_timer_test.sv
module edge_count_timer_test;
  import ect_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        cap_i = 1'b0;
  logic        irq_o;

  int total = 0;
  int bad = 0;

  edge_count_timer uut (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .cap_i, .irq_o
  );

  always #10 clk_i = ~clk_i;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic toggle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      cap_i = ~cap_i;
      repeat (4) @(negedge clk_i);
    end
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    expect_reg("R1 count", A_COUNT, 16'h0);
    expect_reg("R1 ctrl", A_CTRL, 16'h0);
    expect_reg("R1 start", A_START, 16'h0);
    expect_reg("R1 stop", A_STOP, 16'h0);
    expect_reg("R1 raw", A_RAW, 16'h0);
    check("R1 irq", {15'd0, irq_o}, 16'h0);
  endtask

  task automatic t_basic;
    wr(A_START, 16'h000A);
    expect_reg("R10 preload", A_COUNT, 16'h000A);
    wr(A_STOP, 16'h0006);
    wr(A_CTRL, 16'h0007);  // enable, both edges
    toggle(3);
    expect_reg("R2 three edges", A_COUNT, 16'h0007);
    repeat (10) @(negedge clk_i);
    expect_reg("R2 hold", A_COUNT, 16'h0007);
    expect_reg("R4 not yet", A_RAW, 16'h0);
    toggle(1);
    expect_reg("R4 raw set", A_RAW, 16'h1);
    expect_reg("R6 reload", A_COUNT, 16'h000A);
    expect_reg("R6 en clear", A_CTRL, 16'h0006);
    expect_reg("R5 masked off", A_MASKED, 16'h0);
    check("R5 irq off", {15'd0, irq_o}, 16'h0);
    wr(A_MASK, 16'h1);
    expect_reg("R5 masked on", A_MASKED, 16'h1);
    check("R5 irq on", {15'd0, irq_o}, 16'h1);
    toggle(2);
    expect_reg("R7 ignored", A_COUNT, 16'h000A);
    wr(A_RAW, 16'h1);
    expect_reg("R9 cleared", A_RAW, 16'h0);
    check("R9 irq low", {15'd0, irq_o}, 16'h0);
  endtask

  task automatic t_polarity;
    // cap_i is 0 here
    wr(A_START, 16'd20);
    wr(A_STOP, 16'h0);
    wr(A_CTRL, 16'h0001);  // rising only
    toggle(1);
    expect_reg("R3 rising counted", A_COUNT, 16'd19);
    toggle(1);
    expect_reg("R3 falling skipped", A_COUNT, 16'd19);
    wr(A_CTRL, 16'h0003);  // falling only
    toggle(1);
    expect_reg("R3 rising skipped", A_COUNT, 16'd19);
    toggle(1);
    expect_reg("R3 falling counted", A_COUNT, 16'd18);
    wr(A_CTRL, 16'h0005);  // code 10 = both
    toggle(2);
    expect_reg("R3 code10 both", A_COUNT, 16'd16);
    wr(A_START, 16'd30);
    expect_reg("R10 no preload when enabled", A_COUNT, 16'd16);
  endtask

  task automatic t_mode;
    wr(A_CTRL, 16'h000F);  // enabled, both, capture mode 1
    toggle(2);
    expect_reg("R8 mode blocks", A_COUNT, 16'd16);
  endtask

  task automatic t_latency;
    logic [15:0] d;
    wr(A_CTRL, 16'h0007);
    @(negedge clk_i);
    addr_i = A_COUNT;
    cap_i = ~cap_i;
    @(posedge clk_i); @(posedge clk_i); #1 d = rdata_o;
    check("R12 not after two clocks", d, 16'd16);
    @(posedge clk_i); #1 d = rdata_o;
    check("R12 after third clock", d, 16'd15);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_wrap;
    wr(A_CTRL, 16'h0006);  // disable
    wr(A_START, 16'h0001);
    wr(A_STOP, 16'hFFFE);
    wr(A_CTRL, 16'h0007);
    toggle(2);
    expect_reg("R11 wrapped", A_COUNT, 16'hFFFF);
    expect_reg("R11 no early stop", A_RAW, 16'h0);
    toggle(1);
    expect_reg("R11 stop after wrap", A_RAW, 16'h1);
    expect_reg("R11 reload", A_COUNT, 16'h0001);
  endtask

  task automatic t_collide;
    // raw already 1 from the previous match
    wr(A_START, 16'h0002);
    wr(A_STOP, 16'h0001);
    wr(A_CTRL, 16'h0007);
    @(negedge clk_i);
    cap_i = ~cap_i;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = A_RAW; wdata_i = 16'h1;
    @(negedge clk_i);
    we_i = 1'b0;
    expect_reg("R9 set beats clear", A_RAW, 16'h1);
    expect_reg("R9 collide reload", A_COUNT, 16'h0002);
    wr(A_RAW, 16'h1);
    expect_reg("R9 clear after", A_RAW, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_basic;
    t_polarity;
    t_mode;
    t_latency;
    t_wrap;
    t_collide;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule